// File: doc/BRIEF.md
# Evenly Spaced Lookup Table ROM

This block turns an unsigned input value into one word read from a constant table. The table's breakpoints sit at a fixed power-of-two spacing, so the row for a value is its upper bits: a right shift by the base-2 log of the spacing, with no divider in the path. The table always holds a power-of-two number of rows. Rows past the count of real entries read as zero, whatever the parameter array holds there, and so does any value whose row lies past the end of the table.

The word read is captured in a single output register that has no reset. This lets the storage and its register map onto a synchronous block ROM. The result appears one clock after the value is presented. The table contents, the data width, the row count, the spacing and the number of real entries are all parameters. The table cannot be written at run time, and the block does not interpolate between breakpoints.

Top module: `pow2_lut_rom`

## Requirements
- R1: The row for an input is `value_i >> SPACE_LOG2`. Every value in the same row, from `row << SPACE_LOG2` up to `((row + 1) << SPACE_LOG2) - 1`, returns the same word.
- R2: `data_o` shows the word for the `value_i` sampled at a rising edge of `clk_i`, starting just after that edge. The read latency is one cycle.
- R3: The table has `2**IDX_W` rows. Parameter `TABLE` holds them packed, with row i at bits `[i*DATA_W +: DATA_W]`.
- R4: Rows with index at or above `VALID_ROWS` read as zero, even where `TABLE` holds nonzero data for them.
- R5: A value whose row is `2**IDX_W` or more (value >= `2**(IDX_W+SPACE_LOG2)`) reads as zero.
- R6: The output register has no reset. `data_o` changes only at a rising edge of `clk_i`; a change of `value_i` between edges has no effect on `data_o` until the next edge.
- R7: For a row below `VALID_ROWS`, the word returned is exactly the `TABLE` entry of that row, at full `DATA_W` width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the output register captures on the rising edge |
| value_i | input | IN_W | Unsigned value to look up |
| data_o | output | DATA_W | Registered table word, no reset |

## Verification
The assertions check the zero result for padded rows and for values past the table's end on every cycle. They also check, on every cycle, that two consecutive values in the same row leave the output unchanged, and that row zero returns its table word. Only the bench's scenarios show exact word values across all rows against an independently written table model. They also show the one-cycle timing, and that a change of the input between edges leaves the output alone. A full sweep of every input value ties each row boundary to its expected entry.

// File: rtl/lut_pkg.sv
// Package lut_pkg
// Holds the default geometry of the lookup ROM and a function that builds a
// default table image. Assumes the default geometry (16 rows of 8 bits); a
// user choosing other sizes supplies a TABLE of matching width.
package lut_pkg;

    localparam int DEF_IDX_W  = 4;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_ROWS   = 1 << DEF_IDX_W;

    typedef logic [DEF_ROWS*DEF_DATA_W-1:0] def_table_t;

    // Builds a simple nonzero pattern for every row, including padded rows.
    function automatic def_table_t default_table();
        def_table_t img;
        img = '0;
        for (int i = 0; i < DEF_ROWS; i++) begin
            img[i*DEF_DATA_W +: DEF_DATA_W] = DEF_DATA_W'((i * 37 + 5) & 8'hFF);
        end
        return img;
    endfunction

endpackage

// File: rtl/lut_row_index.sv
// Module lut_row_index
// Turns an input value into a table row by a right shift of SPACE_LOG2 bits.
// It flags values whose row lies beyond the 2**IDX_W table rows.
// Assumes IN_W > SPACE_LOG2. Purely combinational.
module lut_row_index #(
    parameter int IN_W       = 9,
    parameter int SPACE_LOG2 = 4,
    parameter int IDX_W      = 4
) (
    input  logic [IN_W-1:0]  value_i,
    output logic [IDX_W-1:0] row_o,
    output logic             in_range_o
);

    localparam int ROW_FULL_W = IN_W - SPACE_LOG2;

    logic [ROW_FULL_W-1:0] row_full;

    // Row number is the upper bits of the value: shift, never divide.
    assign row_full = value_i[IN_W-1:SPACE_LOG2];

    generate
        if (ROW_FULL_W > IDX_W) begin : g_wide
            // Any set bit above the index width means the row is past the table.
            assign row_o      = row_full[IDX_W-1:0];
            assign in_range_o = (row_full[ROW_FULL_W-1:IDX_W] == '0);
        end else begin : g_narrow
            // Every reachable row exists in the table.
            assign row_o      = IDX_W'(row_full);
            assign in_range_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/lut_rom_words.sv
// Module lut_rom_words
// Constant storage of 2**IDX_W words. Rows at or above VALID_ROWS are padded
// with zero, whatever TABLE holds there. An out-of-range request reads zero.
// Assumes VALID_ROWS <= 2**IDX_W. Purely combinational.
module lut_rom_words #(
    parameter int IDX_W      = 4,
    parameter int DATA_W     = 8,
    parameter int VALID_ROWS = 12,
    parameter logic [(1<<IDX_W)*DATA_W-1:0] TABLE = '0
) (
    input  logic [IDX_W-1:0]  row_i,
    input  logic              in_range_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int NUM_ROWS = 1 << IDX_W;

    logic [DATA_W-1:0] words [NUM_ROWS];

    generate
        for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
            if (i < VALID_ROWS) begin : g_real
                // Real entry taken from the parameter image.
                assign words[i] = TABLE[i*DATA_W +: DATA_W];
            end else begin : g_pad
                // Padded entry fixed to zero.
                assign words[i] = '0;
            end
        end
    endgenerate

    // Select the addressed word, or zero when the row is past the table.
    always_comb begin
        word_o = in_range_i ? words[row_i] : '0;
    end

endmodule

// File: rtl/pow2_lut_rom.sv
// Module pow2_lut_rom
// Top of the evenly spaced lookup ROM: shift indexing, padded constant
// storage, and a single output register with no reset so that the
// storage and register can map onto a synchronous block ROM.
// Assumes IN_W > SPACE_LOG2 and VALID_ROWS <= 2**IDX_W.
module pow2_lut_rom #(
    parameter int IN_W       = 9,
    parameter int SPACE_LOG2 = 4,
    parameter int IDX_W      = lut_pkg::DEF_IDX_W,
    parameter int DATA_W     = lut_pkg::DEF_DATA_W,
    parameter int VALID_ROWS = 12,
    parameter logic [(1<<IDX_W)*DATA_W-1:0] TABLE = lut_pkg::default_table()
) (
    input  logic              clk_i,
    input  logic [IN_W-1:0]   value_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int ROW_SPAN = 1 << SPACE_LOG2;

    logic [IDX_W-1:0]  row;
    logic              in_range;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] data_q;

    lut_row_index #(
        .IN_W       (IN_W),
        .SPACE_LOG2 (SPACE_LOG2),
        .IDX_W      (IDX_W)
    ) u_index (
        .value_i    (value_i),
        .row_o      (row),
        .in_range_o (in_range)
    );

    lut_rom_words #(
        .IDX_W      (IDX_W),
        .DATA_W     (DATA_W),
        .VALID_ROWS (VALID_ROWS),
        .TABLE      (TABLE)
    ) u_words (
        .row_i      (row),
        .in_range_i (in_range),
        .word_o     (word)
    );

    // Output register, deliberately without reset, one cycle of latency.
    always_ff @(posedge clk_i) begin
        data_q <= word;
    end

    assign data_o = data_q;

    // Warm-up count so the checks below look back only over sampled cycles.
    logic [1:0] warm_q = 2'd0;
    always_ff @(posedge clk_i) begin
        if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_SAME_ROW_STABLE: assert property (@(posedge clk_i) disable iff (warm_q != 2'd3)
        ($past(value_i >> SPACE_LOG2) == $past(value_i >> SPACE_LOG2, 2)) |-> $stable(data_o)); // R1

    AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (warm_q == 2'd0)
        ((32'($past(value_i)) >> SPACE_LOG2) >= VALID_ROWS) |-> (data_o == '0)); // R4

    AST_PAST_END_ZERO: assert property (@(posedge clk_i) disable iff (warm_q == 2'd0)
        ((32'($past(value_i)) >> SPACE_LOG2) >= (1 << IDX_W)) |-> (data_o == '0)); // R5

    AST_ROW0_WORD: assert property (@(posedge clk_i) disable iff (warm_q == 2'd0)
        ((32'($past(value_i)) < ROW_SPAN) && (VALID_ROWS > 0)) |-> (data_o == TABLE[DATA_W-1:0])); // R7

endmodule

// File: tb/pow2_lut_rom_tb.sv
module pow2_lut_rom_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W   = 9;
    localparam int SLOG   = 4;
    localparam int IDX_W  = 4;
    localparam int DW     = 8;
    localparam int VALID  = 12;
    localparam int ROWS   = 1 << IDX_W;

    // Bench-owned table, different from the package default.
    function automatic logic [ROWS*DW-1:0] tb_table();
        logic [ROWS*DW-1:0] t;
        for (int i = 0; i < ROWS; i++) t[i*DW +: DW] = DW'(((i * 29) + 3) ^ 8'h5A);
        return t;
    endfunction
    localparam logic [ROWS*DW-1:0] TB_TABLE = tb_table();

    // Reference model written from the requirements (uses division).
    function automatic logic [DW-1:0] ref_word(int v);
        int r;
        r = v / (1 << SLOG);
        if (r >= ROWS || r >= VALID) return '0;
        return DW'(((r * 29) + 3) ^ 8'h5A);
    endfunction

    // Stimulus vectors: value and the requirement it targets.
    typedef struct packed { logic [15:0] val; logic [7:0] req; } vec_t;
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   8'd7}, '{16'd15,  8'd1}, '{16'd16,  8'd1}, '{16'd31,  8'd1},
        '{16'd17,  8'd7}, '{16'd100, 8'd7}, '{16'd175, 8'd7}, '{16'd191, 8'd1},
        '{16'd192, 8'd4}, '{16'd255, 8'd4}, '{16'd256, 8'd5}, '{16'd511, 8'd5},
        '{16'd40,  8'd3}, '{16'd176, 8'd3}
    };

    logic            clk = 1'b0;
    logic [IN_W-1:0] value = '0;
    logic [DW-1:0]   data;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pow2_lut_rom #(
        .IN_W(IN_W), .SPACE_LOG2(SLOG), .IDX_W(IDX_W), .DATA_W(DW),
        .VALID_ROWS(VALID), .TABLE(TB_TABLE)
    ) u_dut (
        .clk_i(clk), .value_i(value), .data_o(data)
    );

    task automatic check(string req, logic [DW-1:0] exp, int v);
        checks++;
        if (data !== exp) begin
            failures++;
            $display("FAIL %s value=%0d actual=%0h expected=%0h", req, v, data, exp);
        end
    endtask

    // Present a value at a falling edge, sample just after the next rising edge.
    task automatic apply(int v);
        @(negedge clk);
        value = IN_W'(v);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            apply(int'(VECS[i].val));
            check($sformatf("R%0d", VECS[i].req), ref_word(int'(VECS[i].val)), int'(VECS[i].val));
        end

        // R2: one-cycle latency; before the edge old word, after it new word.
        apply(20);
        @(negedge clk);
        value = IN_W'(130);
        #1;
        check("R2 before edge", ref_word(20), 130);
        @(posedge clk);
        #1;
        check("R2 after edge", ref_word(130), 130);

        // R6: input changes between edges leave the output alone.
        apply(50);
        @(negedge clk);
        value = IN_W'(200);
        #1;
        check("R6 hold", ref_word(50), 200);
        value = IN_W'(300);
        #1;
        check("R6 hold", ref_word(50), 300);
        @(posedge clk);
        #1;
        check("R6 capture", ref_word(300), 300);

        // R4: padded rows read zero though the table holds nonzero there.
        for (int r = VALID; r < ROWS; r++) begin
            apply(r * (1 << SLOG) + 7);
            check("R4 pad row", '0, r * (1 << SLOG) + 7);
        end

        // R1/R3/R5/R7: full sweep of every input value.
        for (int v = 0; v < (1 << IN_W); v++) begin
            apply(v);
            check("R1 R3 R5 R7 sweep", ref_word(v), v);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule